// File: doc/BRIEF.md
# Bit-Serial Fixed-Point Divider Port

This block places a 24-bit fixed-point restoring divider behind a narrow pin interface. Dividend and divisor arrive on two separate one-bit lanes, least significant bit first, one bit per clock, while the `start` input is held high. When `start` falls, the operands are handed to the divider core. The core runs one restoring step per clock for W steps.

When the core finishes, `done` rises and the quotient leaves on a single serial output, least significant bit first, for exactly W clocks. The quotient carries W-1 fractional bits. A host drives the lanes, waits for `done`, collects W bits, and starts the next operation only after `done` has dropped.

The sequencer is a four-state machine:
- IDLE waits for `start`. Its transition IDLE→FILL fires on the first sampled high `start`, and that first bit is captured.
- FILL collects lane bits. Its transition FILL→WORK fires on the first sampled low `start` and launches the core.
- WORK waits for the core. Its transition WORK→DRAIN fires on the core's finish pulse and loads the output shifter.
- DRAIN shifts out the quotient. Its transition DRAIN→IDLE fires after the W-th output bit.

Top module: `serdiv_top`

## Requirements
- R1: While `rst` is high and right after it drops, `done` and `q_out` are 0.
- R2: Both lanes are captured LSB first. The k-th clock edge at which `start` is sampled high stores `x_in` as dividend bit k and `y_in` as divisor bit k, counting from k = 0.
- R3: For a nonzero divisor Y and a dividend X < 2Y, the serial result equals floor(X·2^(W-1)/Y) in W bits. The LSB appears in the cycle where `done` first reads high, and each later bit follows one clock after the previous one.
- R4: `done` rises at the (W+2)-th rising edge, counting the first edge at which `start` is sampled low as edge 1. That is the 26th edge for W = 24.
- R5: `done` stays high for exactly W consecutive cycles, then drops to 0.
- R6: If `start` falls after only n < W bits, those n bits form the low part of each operand and every higher bit is 0.
- R7: While the core computes and while the quotient is shifted out, `start`, `x_in` and `y_in` are ignored. This includes rises and falls of `start`. The result of the current operation is unchanged, and no new operation is launched.
- R8: `q_out` is 0 whenever `done` is low.
- R9: If `start` is held for more than W bits, the extra lane bits are dropped and the first W bits are used.
- R10: A zero divisor produces a quotient of all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Load framing: high while operand bits are presented; its fall launches the divide |
| x_in | input | 1 | Dividend serial lane, LSB first |
| y_in | input | 1 | Divisor serial lane, LSB first |
| q_out | output | 1 | Quotient serial output, LSB first, valid while `done` is high |
| done | output | 1 | High for the W cycles of the quotient readout |

## Verification
- **Bit order.** Operand pairs such as 1/1 and 1/2 give quotients that differ only in which bit is set, so a reversed lane or reversed output order shows up at once.
- **Full-width and edge values.** Full-width values near the X < 2Y limit exercise every restoring decision. Equal operands produce exactly 1.0. A zero divisor produces the all-ones pattern.
- **Load length.** Loads shorter and longer than W bits separate right-aligned zero fill from dropped excess bits.
- **Ignored inputs.** One run toggles `start` and the lanes during the compute and readout phases and then checks that the quotient and the `done` window are unchanged.

// File: rtl/serdiv_pkg.sv
package serdiv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WORK  = 2'd2,
        ST_DRAIN = 2'd3
    } sd_state_t;
endpackage

// File: rtl/serdiv_lane.sv
// One operand capture register: bit addressed by a write index, cleared on a new load.
module serdiv_lane #(
    parameter int W  = 24,
    parameter int IW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic          bit_in,
    output logic [W-1:0]  value
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                value[i] <= 1'b0;
            end else if (wr_en && wr_idx == IW'(i)) begin
                value[i] <= bit_in;
            end else if (clr) begin
                value[i] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/serdiv_core.sv
// Restoring divider, one quotient bit per clock, MSB of quotient first.
module serdiv_core #(
    parameter int W  = 24,
    parameter int KW = $clog2(W)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quot,
    output logic         fin
);
    localparam int RW = W + 1;

    logic [RW-1:0] rem;
    logic [W-1:0]  dvs;
    logic [KW-1:0] step;
    logic          busy;
    logic [RW:0]   trial;
    logic          fits;
    logic [RW-1:0] kept;

    always_comb begin
        trial = {1'b0, rem} - {2'b00, dvs};
        fits  = ~trial[RW];
        kept  = fits ? trial[RW-1:0] : rem;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem  <= '0;
            dvs  <= '0;
            quot <= '0;
            step <= '0;
            busy <= 1'b0;
            fin  <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem  <= {1'b0, dividend};
                dvs  <= divisor;
                quot <= '0;
                step <= '0;
                busy <= 1'b1;
            end else if (busy) begin
                rem  <= {kept[RW-2:0], 1'b0};
                quot <= {quot[W-2:0], fits};
                step <= step + 1'b1;
                if (step == KW'(W - 1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/serdiv_shifter.sv
// Parallel-in, serial-out quotient register, LSB leaves first.
module serdiv_shifter #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         shift,
    input  logic [W-1:0] par_in,
    output logic         ser_out
);
    logic [W-1:0] sreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= par_in;
        end else if (shift) begin
            sreg <= {1'b0, sreg[W-1:1]};
        end
    end

    assign ser_out = sreg[0];
endmodule

// File: rtl/serdiv_top.sv
module serdiv_top
    import serdiv_pkg::*;
#(
    parameter int W = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic x_in,
    input  logic y_in,
    output logic q_out,
    output logic done
);
    localparam int CW = $clog2(W + 1);
    localparam int RW = $clog2(W);

    sd_state_t     state, state_nx;
    logic [CW-1:0] fill_cnt;
    logic [RW-1:0] out_cnt;
    logic          lane_clr, lane_wr;
    logic [CW-1:0] wr_idx;
    logic          core_go, core_fin, ser_load, ser_shift, ser_bit;
    logic [W-1:0]  x_val, y_val, quot;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start)                  state_nx = ST_FILL;
            ST_FILL:  if (!start)                 state_nx = ST_WORK;
            ST_WORK:  if (core_fin)               state_nx = ST_DRAIN;
            ST_DRAIN: if (out_cnt == RW'(W - 1))  state_nx = ST_IDLE;
        endcase
    end

    // outputs of the sequencer
    always_comb begin
        lane_clr  = 1'b0;
        lane_wr   = 1'b0;
        wr_idx    = fill_cnt;
        core_go   = 1'b0;
        ser_load  = 1'b0;
        ser_shift = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: begin
                lane_clr = start;
                lane_wr  = start;
                wr_idx   = '0;
            end
            ST_FILL: begin
                lane_wr = start && (fill_cnt < CW'(W));
                core_go = !start;
            end
            ST_WORK: begin
                ser_load = core_fin;
            end
            ST_DRAIN: begin
                ser_shift = 1'b1;
                done      = 1'b1;
            end
        endcase
    end

    // counters
    always_ff @(posedge clk) begin
        if (rst) begin
            fill_cnt <= '0;
            out_cnt  <= '0;
        end else begin
            if (state == ST_IDLE && start)
                fill_cnt <= CW'(1);
            else if (lane_wr)
                fill_cnt <= fill_cnt + 1'b1;
            if (ser_load)
                out_cnt <= '0;
            else if (ser_shift)
                out_cnt <= out_cnt + 1'b1;
        end
    end

    serdiv_lane #(.W(W)) u_lane_x (
        .clk(clk), .rst(rst), .clr(lane_clr), .wr_en(lane_wr),
        .wr_idx(wr_idx), .bit_in(x_in), .value(x_val)
    );

    serdiv_lane #(.W(W)) u_lane_y (
        .clk(clk), .rst(rst), .clr(lane_clr), .wr_en(lane_wr),
        .wr_idx(wr_idx), .bit_in(y_in), .value(y_val)
    );

    serdiv_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .go(core_go), .dividend(x_val),
        .divisor(y_val), .quot(quot), .fin(core_fin)
    );

    serdiv_shifter #(.W(W)) u_shift (
        .clk(clk), .rst(rst), .load(ser_load), .shift(ser_shift),
        .par_in(quot), .ser_out(ser_bit)
    );

    assign q_out = done & ser_bit;
endmodule

// File: rtl/serdiv_chk.sv
module serdiv_chk
    import serdiv_pkg::*;
#(
    parameter int W = 24
) (
    input logic      clk,
    input logic      rst,
    input logic      done,
    input logic      core_go,
    input logic      core_fin,
    input sd_state_t state
);
    localparam int NW = $clog2(W + 2) + 1;

    logic [NW-1:0] run;
    logic [NW-1:0] gcnt;
    logic          armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= '0;
            gcnt  <= '0;
            armed <= 1'b0;
        end else begin
            if (done && run < NW'(W + 1)) run <= run + 1'b1;
            else if (!done)               run <= '0;
            if (core_go) begin
                armed <= 1'b1;
                gcnt  <= NW'(1);
            end else if (armed) begin
                if (gcnt < NW'(W + 2)) gcnt <= gcnt + 1'b1;
                if (core_fin) armed <= 1'b0;
            end
        end
    end

    // R4: core finishes W steps after launch
    a_r4_fin_latency: assert property (@(posedge clk) disable iff (rst)
        core_fin |-> (armed && gcnt == NW'(W + 1)));

    // R5: readout window never exceeds W cycles
    a_r5_done_max: assert property (@(posedge clk) disable iff (rst)
        done |-> run < NW'(W));

    // R5: readout window is exactly W cycles long
    a_r5_done_full: assert property (@(posedge clk) disable iff (rst)
        $fell(done) |-> run == NW'(W));

    // R3: done rises only after the core has finished
    a_r3_done_after_fin: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(core_fin));

    // R7: compute phase is not left on any input change
    a_r7_work_holds: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WORK && !core_fin) |=> state == ST_WORK);

    // R7: readout only ever returns to idle
    a_r7_drain_exit: assert property (@(posedge clk) disable iff (rst)
        state == ST_DRAIN |=> (state == ST_DRAIN || state == ST_IDLE));
endmodule

bind serdiv_top serdiv_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .done(done),
    .core_go(core_go), .core_fin(core_fin), .state(state)
);

// File: tb/tb_serdiv_top.sv
module tb_serdiv_top;
    localparam int W = 24;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic x_in = 1'b0;
    logic y_in = 1'b0;
    logic q_out, done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    serdiv_top #(.W(W)) dut (
        .clk(clk), .rst(rst), .start(start), .x_in(x_in),
        .y_in(y_in), .q_out(q_out), .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_q(input logic [W-1:0] x, input logic [W-1:0] y);
        logic [47:0] num;
        if (y == '0) return '1;
        num = {24'd0, x} << (W - 1);
        return W'(num / {24'd0, y});
    endfunction

    // Runs one operation; pokes inputs during compute/readout when poke is set.
    task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input int nload,
                          input bit poke, input string tag, input logic [W-1:0] exp);
        logic [W-1:0] qres = '0;
        int lat = 0;
        bit quiet = 1;
        bit held = 1;
        @(negedge clk);
        start = 1'b1;
        for (int i = 0; i < nload; i++) begin
            x_in = (i < W) ? x[i] : 1'b1;
            y_in = (i < W) ? y[i] : 1'b1;
            @(negedge clk);
        end
        start = 1'b0; x_in = 1'b0; y_in = 1'b0;
        while (lat < 100) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            if (done) break;
            if (q_out) quiet = 0;
            if (poke) begin
                start = (lat >= 5 && lat < 9);
                x_in  = lat[0];
                y_in  = ~lat[0];
            end
        end
        start = 1'b0;
        chk(lat == W + 2, {"R4 latency ", tag}, 48'(lat), 48'(W + 2));
        chk(quiet, {"R8 q_out low before done ", tag}, 48'(quiet), 48'd1);
        for (int j = 0; j < W; j++) begin
            if (!done) held = 0;
            qres[j] = q_out;
            if (poke) begin
                start = (j >= 3 && j < 10);
                x_in  = j[0];
            end
            @(negedge clk);
        end
        start = 1'b0; x_in = 1'b0;
        chk(held, {"R5 done held W cycles ", tag}, 48'(held), 48'd1);
        chk(!done && !q_out, {"R5/R8 done drops ", tag}, {46'd0, done, q_out}, 48'd0);
        chk(qres == exp, {"R3 quotient ", tag}, 48'(qres), 48'(exp));
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!done && !q_out, "R1 outputs during reset", {46'd0, done, q_out}, 48'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !q_out, "R1 outputs after reset", {46'd0, done, q_out}, 48'd0);
    endtask

    task automatic t_bit_order();
        run_op(24'h000001, 24'h000001, W, 0, "R2 1/1", 24'h800000);
        run_op(24'h000001, 24'h000002, W, 0, "R2 1/2", 24'h400000);
    endtask

    task automatic t_full_width();
        run_op(24'hE51234, 24'hFCB2AA, W, 0, "R3 frac", ref_q(24'hE51234, 24'hFCB2AA));
        run_op(24'h7FFFFF, 24'h400000, W, 0, "R3 near 2", ref_q(24'h7FFFFF, 24'h400000));
        run_op(24'hABCDEF, 24'hABCDEF, W, 0, "R3 equal", 24'h800000);
    endtask

    task automatic t_short_load();
        // R6: only 8 bits loaded, upper bits must be zero
        run_op(24'hFF00C3, 24'hFF0081, 8, 0, "R6 short", ref_q(24'h0000C3, 24'h000081));
    endtask

    task automatic t_long_load();
        // R9: 30 bits presented, extra ones dropped
        run_op(24'h123456, 24'h654321, 30, 0, "R9 long", ref_q(24'h123456, 24'h654321));
    endtask

    task automatic t_zero_div();
        run_op(24'h345678, 24'h000000, W, 0, "R10 zero", 24'hFFFFFF);
    endtask

    task automatic t_ignore();
        bit calm = 1;
        run_op(24'h5A5A5A, 24'h6B6B6B, W, 1, "R7 poke", ref_q(24'h5A5A5A, 24'h6B6B6B));
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done) calm = 0;
        end
        chk(calm, "R7 no relaunch after poke", 48'(calm), 48'd1);
        run_op(24'h000003, 24'h000004, W, 0, "R7 after poke", 24'h600000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_bit_order();
        t_full_width();
        t_short_load();
        t_long_load();
        t_zero_div();
        t_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule